// File: doc/BRIEF.md
# Acknowledged Packet Transmit Sequencer

This block is the transmit half of an acknowledged packet radio link. It looks after one payload at a time, taken from the head of a transmit queue. The block sends the payload, listens for an acknowledgement for a programmable time, and sends the payload again after each silent window until a programmed retry budget is used up. The framing, the modulation and the queue storage live in neighbouring blocks. This block only decides when a frame goes out and what happens after it.

A chip-enable input moves the block out of its idle standby. The enable must be held for a qualification time. Each attempt then waits for a settling time before it asks the link layer for a frame. Two sticky flags report the outcome of a payload: one for delivery and one for retry exhaustion. Each flag is cleared by a one-cycle write-one pulse. An active-low interrupt follows the two flags. A 4-bit counter keeps the number of payloads given up. All time constants are set in microseconds. A clock prescaler turns them into cycles.

The queue head is offered on a valid/ready pair: `pkt_valid` from the queue and `pkt_take` from this block. `pkt_take` is raised only while `pkt_valid` is high. It is high for exactly the cycle in which the acknowledgement is accepted, and the queue pops its head on that clock edge. The queue has to keep the head stable, and `pkt_valid` high, from the launch of a payload until it is taken. The block never pushes back on the queue: it takes a payload only on delivery, so a payload that is given up stays queued.

Top module: `arc_tx_ctrl`

## Requirements
- R1: A launch needs `ce` to stay high for CE_HOLD_US microseconds, followed by SETTLE_US microseconds of settling, before `tx_go` pulses. If `ce` falls before the hold time ends, no frame is sent.
- R2: `mode` reads 0 (standby, enable low) while `ce` is low and nothing is in flight. It reads 2 (standby, enable high) when `ce` is high and either no payload is pending or sending is blocked.
- R3: After `tx_done`, the block listens for (`retry_delay`+1)×DELAY_STEP_US microseconds. An `ack_seen` outside that window has no effect on `pkt_take` or the flags.
- R4: An `ack_seen` inside the window raises `pkt_take` in the same cycle and sets `tx_ds` on the next edge.
- R5: When a window ends with no ack, the payload is sent again after a fresh settle period. A payload gets at most `retry_limit`+1 attempts.
- R6: When the last attempt's window ends with no ack, `max_rt` is set and the payload is not taken. No `tx_go` occurs while `max_rt` is set. Clearing it lets the pending payload be sent again.
- R7: `lost_cnt` goes up by one for each `max_rt` event and saturates at 15. A `chan_wr` pulse resets it to 0.
- R8: `irq_n` is low exactly while `tx_ds` or `max_rt` is set. `clr_ds` clears only `tx_ds`, and `clr_rt` clears only `max_rt`.
- R9: `tx_go` is a one-cycle pulse, given once per attempt.
- R10: After reset, `mode`=0, both flags are 0, `irq_n`=1, `lost_cnt`=0, and `tx_go` and `pkt_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Chip enable from the host |
| retry_limit | input | 4 | Number of resends allowed after the first attempt |
| retry_delay | input | 4 | Ack window in steps of DELAY_STEP_US, minus one |
| pkt_valid | input | 1 | Queue head present |
| pkt_take | output | 1 | Pop the queue head (ready) |
| tx_go | output | 1 | Pulse: link layer should send the head frame |
| tx_done | input | 1 | Pulse: link layer finished sending the frame |
| ack_seen | input | 1 | Pulse: acknowledgement received |
| clr_ds | input | 1 | Write-one clear of `tx_ds` |
| clr_rt | input | 1 | Write-one clear of `max_rt` |
| chan_wr | input | 1 | RF channel register written; resets `lost_cnt` |
| tx_ds | output | 1 | Delivery flag |
| max_rt | output | 1 | Retry exhaustion flag |
| irq_n | output | 1 | Interrupt, active low |
| lost_cnt | output | 4 | Count of payloads given up |
| mode | output | 3 | State: 0 idle standby, 1 enable qualify, 2 enabled standby, 3 settle, 4 sending, 5 ack wait |

## Verification
The assertions assume a well-behaved link layer and queue. `tx_done` comes only as one pulse while a frame is in flight. `ack_seen` is a one-cycle pulse. `pkt_valid` is not withdrawn during an attempt. `chan_wr` never lands in the same cycle as a retry exhaustion. The bench acts as that link layer and queue. It answers each `tx_go` with one `tx_done` two cycles later and gives at most one ack pulse per attempt. It flushes its queue model only while `ce` is low and the block has fallen back to standby.

// File: rtl/arc_pkg.sv
package arc_pkg;
  localparam int RETRY_W = 4;
  localparam int LOST_W  = 4;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_QUAL   = 3'd1,
    M_HOLD   = 3'd2,
    M_SETTLE = 3'd3,
    M_SEND   = 3'd4,
    M_WAIT   = 3'd5
  } mode_e;
endpackage

// File: rtl/arc_tick.sv
// Microsecond strobe from the core clock.
module arc_tick #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CYC_PER_US <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CYC_PER_US);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             div_q <= '0;
        else if (div_q == DW'(CYC_PER_US - 1))  div_q <= '0;
        else                                    div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(CYC_PER_US - 1));
    end
  endgenerate
endmodule

// File: rtl/arc_timer.sv
// Down counter in microsecond ticks; load N-1 to expire after N ticks.
module arc_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = tick && (cnt_q == '0);
endmodule

// File: rtl/arc_flags.sv
// Outcome flags, interrupt and saturating loss counter.
module arc_flags #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_ds,
  input  logic          set_rt,
  input  logic          clr_ds,
  input  logic          clr_rt,
  input  logic          chan_wr,
  output logic          tx_ds,
  output logic          max_rt,
  output logic          irq_n,
  output logic [LW-1:0] lost_cnt
);
  localparam logic [LW-1:0] LOST_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ds    <= 1'b0;
      max_rt   <= 1'b0;
      lost_cnt <= '0;
    end else begin
      if (set_ds)      tx_ds <= 1'b1;
      else if (clr_ds) tx_ds <= 1'b0;

      if (set_rt)      max_rt <= 1'b1;
      else if (clr_rt) max_rt <= 1'b0;

      if (chan_wr)                          lost_cnt <= '0;
      else if (set_rt && lost_cnt != LOST_TOP) lost_cnt <= lost_cnt + 1'b1;
    end
  end

  assign irq_n = !(tx_ds || max_rt);
endmodule

// File: rtl/arc_tx_ctrl.sv
module arc_tx_ctrl
  import arc_pkg::*;
#(
  parameter int CYC_PER_US    = 100,
  parameter int CE_HOLD_US    = 10,
  parameter int SETTLE_US     = 130,
  parameter int DELAY_STEP_US = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic [RETRY_W-1:0] retry_delay,
  input  logic               pkt_valid,
  output logic               pkt_take,
  output logic               tx_go,
  input  logic               tx_done,
  input  logic               ack_seen,
  input  logic               clr_ds,
  input  logic               clr_rt,
  input  logic               chan_wr,
  output logic               tx_ds,
  output logic               max_rt,
  output logic               irq_n,
  output logic [LOST_W-1:0]  lost_cnt,
  output logic [2:0]         mode
);
  localparam int DLY_MAX = (1 << RETRY_W) * DELAY_STEP_US;
  localparam int T_A     = (DLY_MAX > SETTLE_US) ? DLY_MAX : SETTLE_US;
  localparam int T_MAX   = (T_A > CE_HOLD_US) ? T_A : CE_HOLD_US;
  localparam int TW      = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] HOLD_LD   = TW'(CE_HOLD_US - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_US - 1);

  mode_e              st_q, st_d;
  logic [RETRY_W-1:0] try_q;
  logic               go_q;
  logic               tick, expired;
  logic               ld;
  logic [TW-1:0]      ld_val;
  logic               launch, set_ds, set_rt, try_clr, try_inc;
  logic               can_send;
  logic [TW-1:0]      dly_ld;

  assign dly_ld   = TW'((int'(retry_delay) + 1) * DELAY_STEP_US - 1);
  assign can_send = ce && pkt_valid && !max_rt;

  arc_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  arc_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(ld), .load_val(ld_val), .expired(expired)
  );

  arc_flags #(.LW(LOST_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_ds(set_ds), .set_rt(set_rt),
    .clr_ds(clr_ds), .clr_rt(clr_rt), .chan_wr(chan_wr),
    .tx_ds(tx_ds), .max_rt(max_rt), .irq_n(irq_n), .lost_cnt(lost_cnt)
  );

  always_comb begin
    st_d     = st_q;
    ld       = 1'b0;
    ld_val   = '0;
    launch   = 1'b0;
    pkt_take = 1'b0;
    set_ds   = 1'b0;
    set_rt   = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    unique case (st_q)
      M_IDLE: if (ce) begin
        st_d = M_QUAL; ld = 1'b1; ld_val = HOLD_LD;
      end
      M_QUAL: begin
        if (!ce)          st_d = M_IDLE;
        else if (expired) st_d = M_HOLD;
      end
      M_HOLD: begin
        if (!ce) st_d = M_IDLE;
        else if (can_send) begin
          st_d = M_SETTLE; ld = 1'b1; ld_val = SETTLE_LD;
        end
      end
      M_SETTLE: if (expired) begin
        st_d = M_SEND; launch = 1'b1;
      end
      M_SEND: if (tx_done) begin
        st_d = M_WAIT; ld = 1'b1; ld_val = dly_ld;
      end
      M_WAIT: begin
        if (ack_seen && pkt_valid) begin
          pkt_take = 1'b1;
          set_ds   = 1'b1;
          try_clr  = 1'b1;
          st_d     = ce ? M_HOLD : M_IDLE;
        end else if (expired) begin
          if (try_q == retry_limit) begin
            set_rt  = 1'b1;
            try_clr = 1'b1;
            st_d    = ce ? M_HOLD : M_IDLE;
          end else begin
            try_inc = 1'b1;
            st_d    = M_SETTLE; ld = 1'b1; ld_val = SETTLE_LD;
          end
        end
      end
      default: st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      try_q <= '0;
      go_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      go_q <= launch;
      if (try_clr)      try_q <= '0;
      else if (try_inc) try_q <= try_q + 1'b1;
    end
  end

  assign tx_go = go_q;
  assign mode  = st_q;
endmodule

// File: rtl/arc_tx_chk.sv
module arc_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic       pkt_take,
  input logic       tx_go,
  input logic       tx_ds,
  input logic       max_rt,
  input logic [3:0] lost_cnt
);
  a_r4_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_take |-> pkt_valid);

  a_r4_ds_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ds) |-> $past(pkt_take));

  a_r6_no_send_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> !max_rt);

  a_r9_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

  a_r7_lost_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_cnt != $past(lost_cnt)) |-> (lost_cnt == $past(lost_cnt) + 4'd1 || lost_cnt == 4'd0));

  a_r7_lost_on_rt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(max_rt) |-> (!$stable(lost_cnt) || lost_cnt == 4'd15));
endmodule

bind arc_tx_ctrl arc_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_take(pkt_take),
  .tx_go(tx_go), .tx_ds(tx_ds), .max_rt(max_rt), .lost_cnt(lost_cnt)
);

// File: tb/test_arc_tx_ctrl.sv
module test_arc_tx_ctrl;
  localparam int HOLD = 3;
  localparam int SETL = 5;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic [3:0] retry_limit = '0;
  logic [3:0] retry_delay = '0;
  logic pkt_valid, pkt_take, tx_go;
  logic tx_done = 1'b0, ack_seen = 1'b0;
  logic clr_ds = 1'b0, clr_rt = 1'b0, chan_wr = 1'b0;
  logic tx_ds, max_rt, irq_n;
  logic [3:0] lost_cnt;
  logic [2:0] mode;

  int fifo_n = 0;
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  assign pkt_valid = (fifo_n != 0);

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  arc_tx_ctrl #(.CYC_PER_US(1), .CE_HOLD_US(HOLD), .SETTLE_US(SETL),
                .DELAY_STEP_US(STEP)) i_arc_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .retry_limit(retry_limit),
    .retry_delay(retry_delay), .pkt_valid(pkt_valid), .pkt_take(pkt_take),
    .tx_go(tx_go), .tx_done(tx_done), .ack_seen(ack_seen), .clr_ds(clr_ds),
    .clr_rt(clr_rt), .chan_wr(chan_wr), .tx_ds(tx_ds), .max_rt(max_rt),
    .irq_n(irq_n), .lost_cnt(lost_cnt), .mode(mode)
  );

  // {retry_limit, retry_delay, ack on attempt (0 = never), expected attempts, 3'b0, expected delivery}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {4'd3, 4'd0, 4'd1, 4'd1, 4'd1},
    {4'd3, 4'd1, 4'd3, 4'd3, 4'd1},
    {4'd2, 4'd0, 4'd0, 4'd3, 4'd0},
    {4'd0, 4'd0, 4'd0, 4'd1, 4'd0},
    {4'd0, 4'd2, 4'd1, 4'd1, 4'd1},
    {4'd5, 4'd0, 4'd6, 4'd6, 4'd1},
    {4'd1, 4'd0, 4'd5, 4'd2, 4'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wait_go(input int limit, output bit got);
    got = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (tx_go) begin got = 1; return; end
    end
  endtask

  task automatic send_done();
    @(negedge clk);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic give_ack(output bit took);
    @(negedge clk); ack_seen = 1'b1;
    #1 took = pkt_take;
    @(negedge clk); ack_seen = 1'b0;
    if (took) fifo_n--;
  endtask

  task automatic cleanup();
    @(negedge clk); ce = 1'b0;
    repeat (3) @(negedge clk);
    fifo_n = 0;
    clr_ds = 1'b1; clr_rt = 1'b1;
    @(negedge clk); clr_ds = 1'b0; clr_rt = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit got, took;
    int lat, t_done, t_go, lost0, att;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "mode", mode, 0);
    chk("R10", "irq_n", irq_n, 1);
    chk("R10", "flags", {tx_ds, max_rt}, 0);
    chk("R10", "lost_cnt", lost_cnt, 0);
    chk("R10", "go/take", {tx_go, pkt_take}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 standby-II with empty queue
    ce = 1'b1;
    repeat (HOLD + 4) @(negedge clk);
    chk("R2", "mode enabled empty", mode, 2);
    // R3 stray ack ignored
    ack_seen = 1'b1;
    #1 chk("R3", "take on stray ack", pkt_take, 0);
    @(negedge clk); ack_seen = 1'b0;
    @(negedge clk);
    chk("R3", "tx_ds after stray ack", tx_ds, 0);
    ce = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "mode enable low", mode, 0);

    // R1 short enable pulse
    fifo_n = 1;
    ce = 1'b1;
    @(negedge clk); ce = 1'b0;
    wait_go(40, got);
    chk("R1", "go after short ce", got, 0);
    chk("R2", "mode after short ce", mode, 0);

    // R1 launch latency
    ce = 1'b1; lat = cyc;
    wait_go(100, got);
    lat = cyc - lat;
    chk("R1", "launch seen", got, 1);
    chk_rng("R1", "launch latency", lat, HOLD + SETL, HOLD + SETL + 3);
    @(negedge clk);
    chk("R9", "go width", tx_go, 0);
    send_done();
    give_ack(took);
    chk("R4", "take on ack", took, 1);
    @(negedge clk);
    chk("R8", "irq on ds", irq_n, 0);
    clr_rt = 1'b1;
    @(negedge clk); clr_rt = 1'b0;
    chk("R8", "clr_rt keeps ds", tx_ds, 1);
    cleanup();
    chk("R8", "irq released", irq_n, 1);

    // Table of retry scenarios (R3, R4, R5, R6, R7)
    for (int v = 0; v < NV; v++) begin
      retry_limit = VEC[v][19:16];
      retry_delay = VEC[v][15:12];
      fifo_n = 1;
      att = 0; took = 0; t_done = 0;
      lost0 = lost_cnt;
      ce = 1'b1;
      for (int k = 1; k <= 16; k++) begin
        wait_go(200, got);
        if (!got) break;
        t_go = cyc;
        att++;
        if (k > 1)
          chk_rng("R3", "retry gap", t_go - t_done,
                  (int'(retry_delay) + 1) * STEP + SETL,
                  (int'(retry_delay) + 1) * STEP + SETL + 3);
        @(negedge clk);
        @(negedge clk); tx_done = 1'b1; t_done = cyc;
        @(negedge clk); tx_done = 1'b0;
        if (k == int'(VEC[v][11:8])) begin
          give_ack(took);
          break;
        end
      end
      repeat (3) @(negedge clk);
      chk("R5", "attempts", att, int'(VEC[v][7:4]));
      chk("R4", "taken", took, int'(VEC[v][0]));
      chk("R4", "tx_ds", tx_ds, int'(VEC[v][0]));
      chk("R6", "max_rt", max_rt, int'(!VEC[v][0]));
      chk("R6", "payload kept", fifo_n, int'(!VEC[v][0]));
      chk("R7", "lost step", lost_cnt, lost0 + int'(!VEC[v][0]));
      chk("R8", "irq asserted", irq_n, 0);
      cleanup();
      chk("R8", "irq clear", irq_n, 1);
    end

    // R6 blocking until max_rt cleared
    retry_limit = 4'd0; retry_delay = 4'd0;
    fifo_n = 1; ce = 1'b1;
    wait_go(100, got);
    send_done();
    repeat (20) @(negedge clk);
    chk("R6", "max_rt set", max_rt, 1);
    att = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_go || pkt_take) att++;
    end
    chk("R6", "activity while blocked", att, 0);
    chk("R2", "mode while blocked", mode, 2);
    clr_ds = 1'b1;
    @(negedge clk); clr_ds = 1'b0;
    chk("R8", "clr_ds keeps rt", max_rt, 1);
    clr_rt = 1'b1;
    @(negedge clk); clr_rt = 1'b0;
    wait_go(100, got);
    chk("R6", "resend after clear", got, 1);
    send_done();
    give_ack(took);
    chk("R4", "take after resend", took, 1);
    cleanup();

    // R7 reset by channel write and saturation
    chan_wr = 1'b1;
    @(negedge clk); chan_wr = 1'b0;
    @(negedge clk);
    chk("R7", "lost after chan_wr", lost_cnt, 0);
    for (int n = 0; n < 17; n++) begin
      fifo_n = 1; ce = 1'b1;
      wait_go(100, got);
      send_done();
      repeat (10) @(negedge clk);
      cleanup();
    end
    chk("R7", "lost saturates", lost_cnt, 15);
    chan_wr = 1'b1;
    @(negedge clk); chan_wr = 1'b0;
    @(negedge clk);
    chk("R7", "lost cleared", lost_cnt, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule